// File: doc/BRIEF.md
# Pixel Cluster Rejection Filter

This block cleans a binary hit map from one sensor plane before the map goes to the partner plane for coincidence. On every bunch-crossing clock it takes a ROWS x COLS map of hits. It removes every hit that belongs to a group of three or more touching pixels and passes single hits and two-hit pairs through unchanged. Pixels touch when they are adjacent horizontally, vertically or diagonally.

Each pixel looks at the 3x3 window around itself. A lit pixel with two or more lit neighbours raises a local reject flag. A hit survives only if neither it nor any of its eight neighbours has a raised flag. This removes every connected group of three or more as a whole. Every pixel in such a group either has two lit neighbours or sits next to one that does. The map enters a register stage, the flags and the survivors are computed, and the cleaned map is registered at the output. A new map is accepted every cycle, and a valid flag travels alongside the maps.

Top module: `pixel_cluster_filter`

## Requirements
- R1: While rst_n is low at a rising clock edge, out_map and out_valid are zero after that edge, whatever the inputs.
- R2: out_valid at any cycle equals in_valid sampled two rising edges earlier. The fixed latency is two cycles.
- R3: A hit with no lit pixel among its eight neighbours appears on out_map two cycles later. Pixel (row r, column c) is bit r*COLS+c of both maps.
- R4: Two lit pixels that touch orthogonally or diagonally, with no other lit pixel touching either of them, both pass.
- R5: Every pixel of an 8-connected group of three or more lit pixels is cleared on out_map. This covers lines, L shapes, long chains and a fully lit map.
- R6: Positions outside the grid count as unlit. Hits on edges and corners follow R3 to R5 with only their in-grid neighbours.
- R7: out_map never holds a hit that was not set in the in_map sampled two edges earlier.
- R8: A new map is accepted on every cycle. Back-to-back maps are filtered independently of each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Marks in_map as carrying a crossing |
| in_map | input | ROWS*COLS | Raw hit map, bit r*COLS+c is pixel (r,c) |
| out_valid | output | 1 | in_valid delayed by two cycles |
| out_map | output | ROWS*COLS | Cleaned hit map |

## Verification
The filter holds no state beyond its two pipeline registers, so any fault shows up in the cleaned map of the very crossing that triggers it, exactly two cycles after that map enters. A flag that is wrongly raised or dropped either removes a lone hit or pair, or lets part of a larger group through. The bench compares each output against a connected-component model that labels groups and counts their sizes. A broken edge treatment appears as wrong survivors along the border rows and columns. A broken pipeline appears as maps or valid flags shifted by a cycle.

// File: rtl/cf_pkg.sv
// Shared types for the pixel cluster rejection filter.
package cf_pkg;
    // 3x3 neighbourhood, bit index 3*dr+dc with dr,dc in 0..2; bit 4 is the centre.
    typedef logic [8:0] window_t;
    localparam int CENTRE = 4;
endpackage

// File: rtl/cf_stage_reg.sv
// Pipeline register for a map and its valid flag.
// Assumes a synchronous active-low reset that clears both.
module cf_stage_reg #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         d_valid,
    input  logic [W-1:0] d_data,
    output logic         q_valid,
    output logic [W-1:0] q_data
);
    // Capture map and flag each cycle; reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_data  <= '0;
        end else begin
            q_valid <= d_valid;
            q_data  <= d_data;
        end
    end
endmodule

// File: rtl/cf_flag_cell.sv
// Reject flag for one pixel: raised when the centre is lit and at least
// two of its eight neighbours are lit. Assumes out-of-grid bits are zero.
module cf_flag_cell (
    input  cf_pkg::window_t win,
    output logic            flag
);
    logic [3:0] lit_cnt;

    // Count lit neighbours, excluding the centre.
    always_comb begin
        lit_cnt = '0;
        for (int i = 0; i < 9; i++) begin
            if (i != cf_pkg::CENTRE) lit_cnt = lit_cnt + 4'(win[i]);
        end
    end

    // Flag only lit pixels, so two separated hits do not mark the gap between them.
    always_comb flag = win[cf_pkg::CENTRE] && (lit_cnt >= 4'd2);
endmodule

// File: rtl/cf_keep_cell.sv
// Survivor decision for one pixel: the hit stays only if no flag is
// raised in its 3x3 window (its own flag included).
module cf_keep_cell (
    input  logic            hit,
    input  cf_pkg::window_t flags,
    output logic            keep
);
    // Any flag nearby removes the hit.
    always_comb keep = hit && !(|flags);
endmodule

// File: rtl/pixel_cluster_filter.sv
// Removes every 8-connected group of three or more hits from a ROWS x COLS
// binary map. Stage 1 registers the raw map. Flags and survivors are found
// combinationally, and stage 2 registers the cleaned map. Latency is 2 cycles
// with one map accepted per cycle. Pixel (r,c) is bit r*COLS+c.
module pixel_cluster_filter #(
    parameter int ROWS = 8,
    parameter int COLS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [ROWS*COLS-1:0] in_map,
    output logic                 out_valid,
    output logic [ROWS*COLS-1:0] out_map
);
    localparam int NPIX = ROWS * COLS;

    logic                        s1_valid;
    logic [NPIX-1:0]             s1_map;
    logic [NPIX-1:0]             flag_vec;
    logic [NPIX-1:0]             keep_vec;
    logic [ROWS+1:0][COLS+1:0]   hit_pad;
    logic [ROWS+1:0][COLS+1:0]   flag_pad;

    cf_stage_reg #(.W(NPIX)) u_in_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_valid (in_valid),
        .d_data  (in_map),
        .q_valid (s1_valid),
        .q_data  (s1_map)
    );

    // Embed the hit map in a zero border so edge pixels see unlit neighbours.
    always_comb begin
        hit_pad = '0;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                hit_pad[r+1][c+1] = s1_map[r*COLS+c];
    end

    // Embed the flag map in a zero border in the same way.
    always_comb begin
        flag_pad = '0;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                flag_pad[r+1][c+1] = flag_vec[r*COLS+c];
    end

    for (genvar rr = 0; rr < ROWS; rr++) begin : g_row
        for (genvar cc = 0; cc < COLS; cc++) begin : g_col
            localparam int IDX = rr * COLS + cc;
            cf_pkg::window_t hwin;
            cf_pkg::window_t fwin;
            for (genvar dr = 0; dr < 3; dr++) begin : g_dr
                for (genvar dc = 0; dc < 3; dc++) begin : g_dc
                    assign hwin[dr*3+dc] = hit_pad[rr+dr][cc+dc];
                    assign fwin[dr*3+dc] = flag_pad[rr+dr][cc+dc];
                end
            end
            cf_flag_cell u_flag (
                .win  (hwin),
                .flag (flag_vec[IDX])
            );
            cf_keep_cell u_keep (
                .hit   (s1_map[IDX]),
                .flags (fwin),
                .keep  (keep_vec[IDX])
            );
        end
    end

    cf_stage_reg #(.W(NPIX)) u_out_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_valid (s1_valid),
        .d_data  (keep_vec),
        .q_valid (out_valid),
        .q_data  (out_map)
    );
endmodule

// File: rtl/cf_filter_chk.sv
// Port-level checker for pixel_cluster_filter. It keeps its own two-cycle
// history of the inputs and relates it to the outputs.
module cf_filter_chk #(
    parameter int ROWS = 8,
    parameter int COLS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [ROWS*COLS-1:0] in_map,
    input logic                 out_valid,
    input logic [ROWS*COLS-1:0] out_map
);
    localparam int NPIX = ROWS * COLS;

    logic [NPIX-1:0] map_d1, map_d2, iso_now, iso_d1, iso_d2;
    logic            val_d1, val_d2;

    // Hits with no lit pixel anywhere around them in the incoming map.
    always_comb begin
        iso_now = '0;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                logic any_nb;
                any_nb = 1'b0;
                for (int dr = -1; dr <= 1; dr++)
                    for (int dc = -1; dc <= 1; dc++)
                        if ((dr != 0 || dc != 0) && r+dr >= 0 && r+dr < ROWS &&
                            c+dc >= 0 && c+dc < COLS)
                            any_nb = any_nb | in_map[(r+dr)*COLS + (c+dc)];
                iso_now[r*COLS+c] = in_map[r*COLS+c] & ~any_nb;
            end
        end
    end

    // Two-cycle history of the inputs, cleared by reset like the design.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_d1 <= '0; map_d2 <= '0;
            iso_d1 <= '0; iso_d2 <= '0;
            val_d1 <= 1'b0; val_d2 <= 1'b0;
        end else begin
            map_d1 <= in_map;  map_d2 <= map_d1;
            iso_d1 <= iso_now; iso_d2 <= iso_d1;
            val_d1 <= in_valid; val_d2 <= val_d1;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (out_map == '0 && !out_valid));

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == val_d2);

    // R3
    isolated_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iso_d2 & ~out_map) == '0);

    // R7
    no_new_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_map & ~map_d2) == '0);
endmodule

bind pixel_cluster_filter cf_filter_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_map    (in_map),
    .out_valid (out_valid),
    .out_map   (out_map)
);

// File: tb/tb_pixel_cluster_filter.sv
`timescale 1ns/1ps
module tb_pixel_cluster_filter;
    localparam int ROWS = 8;
    localparam int COLS = 8;
    localparam int NPIX = ROWS * COLS;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [NPIX-1:0] in_map = '0;
    logic            out_valid;
    logic [NPIX-1:0] out_map;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [NPIX-1:0] exp_map [2];
    logic            exp_val [2];
    string           exp_tag [2];

    pixel_cluster_filter #(.ROWS(ROWS), .COLS(COLS)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_map(in_map),
        .out_valid(out_valid), .out_map(out_map)
    );

    always #2 clk = ~clk;

    // Reference model: label 8-connected groups, keep only groups smaller than 3.
    function automatic logic [NPIX-1:0] ref_clean(input logic [NPIX-1:0] m);
        int lbl [NPIX];
        int sz  [NPIX];
        logic [NPIX-1:0] res;
        bit changed;
        for (int i = 0; i < NPIX; i++) begin lbl[i] = i; sz[i] = 0; end
        changed = 1;
        while (changed) begin
            changed = 0;
            for (int i = 0; i < NPIX; i++) begin
                if (m[i]) begin
                    for (int dr = -1; dr <= 1; dr++)
                        for (int dc = -1; dc <= 1; dc++) begin
                            int r, c;
                            r = i / COLS + dr; c = i % COLS + dc;
                            if (r >= 0 && r < ROWS && c >= 0 && c < COLS &&
                                m[r*COLS+c] && lbl[r*COLS+c] < lbl[i]) begin
                                lbl[i] = lbl[r*COLS+c];
                                changed = 1;
                            end
                        end
                end
            end
        end
        for (int i = 0; i < NPIX; i++) if (m[i]) sz[lbl[i]]++;
        res = '0;
        for (int i = 0; i < NPIX; i++) if (m[i] && sz[lbl[i]] < 3) res[i] = 1'b1;
        return res;
    endfunction

    function automatic logic [NPIX-1:0] px(input int r, input int c);
        logic [NPIX-1:0] v;
        v = '0;
        v[r*COLS+c] = 1'b1;
        return v;
    endfunction

    // One crossing: check the result of the map driven two steps ago, then drive a new one.
    task automatic step(input logic [NPIX-1:0] m, input logic v, input string tag);
        @(negedge clk);
        checks++;
        if (out_map !== exp_map[1]) begin
            errors++;
            $display("FAIL %s out_map actual=%h expected=%h", exp_tag[1], out_map, exp_map[1]);
        end
        checks++;
        if (out_valid !== exp_val[1]) begin
            errors++;
            $display("FAIL R2 out_valid actual=%b expected=%b", out_valid, exp_val[1]);
        end
        in_map = m;
        in_valid = v;
        exp_map[1] = exp_map[0]; exp_val[1] = exp_val[0]; exp_tag[1] = exp_tag[0];
        exp_map[0] = ref_clean(m); exp_val[0] = v; exp_tag[0] = tag;
    endtask

    function automatic logic [NPIX-1:0] rand_map(input int sparse);
        logic [NPIX-1:0] v;
        for (int i = 0; i < NPIX; i++) v[i] = (($urandom % sparse) == 0);
        return v;
    endfunction

    initial begin
        logic [NPIX-1:0] m;
        void'($urandom(32'd4021));
        exp_map[0] = '0; exp_map[1] = '0;
        exp_val[0] = 1'b0; exp_val[1] = 1'b0;
        exp_tag[0] = "R1"; exp_tag[1] = "R1";
        // R1: reset with busy inputs must leave outputs clear
        in_map = '1; in_valid = 1'b1;
        repeat (3) @(negedge clk);
        checks++;
        if (out_map !== '0 || out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset actual=%h/%b expected=0/0", out_map, out_valid);
        end
        in_map = '0; in_valid = 1'b0; rst_n = 1'b1;

        step(px(3, 4), 1, "R3 isolated centre");
        step(px(0, 0) | px(7, 7) | px(0, 7), 1, "R6 isolated corners");
        step(px(2, 2) | px(2, 3), 1, "R4 horizontal pair");
        step(px(4, 4) | px(5, 5) | px(0, 0), 0, "R4 diagonal pair");
        step(px(1, 1) | px(1, 2) | px(1, 3) | px(6, 6), 1, "R5 line of three");
        step(px(3, 3) | px(4, 3) | px(4, 4), 1, "R5 L shape");
        m = '0;
        for (int k = 0; k < 6; k++) m |= px(k, k);
        m |= px(0, 6) | px(1, 7) | px(7, 0);
        step(m, 1, "R5 diagonal chain with pair and single");
        step(px(0, 0) | px(0, 1) | px(1, 0), 1, "R6 corner triple");
        step(px(7, 3) | px(7, 4) | px(0, 3) | px(0, 4), 1, "R6 edge pairs");
        step('1, 1, "R5 full map");
        step(px(2, 0) | px(2, 2), 1, "R3 hits with a gap");
        step(px(5, 1) | px(5, 2) | px(5, 3) | px(5, 4) | px(5, 5), 0, "R5 long line");
        for (int n = 0; n < 150; n++) begin
            step(rand_map((n % 3 == 0) ? 4 : 10), 1'($urandom % 2), "R8 random back-to-back");
        end
        step('0, 0, "R8 flush");
        step('0, 0, "R8 flush");
        step('0, 0, "R8 flush");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule